// File: doc/BRIEF.md
# Shared Register Control Generator for a Ten-Cell Logic Group

This block is the control section shared by a group of logic cells. Each cell owns four storage registers, so the default group holds forty of them. A small set of incoming control lines is routed into six shared control slots: two clock enables, two synchronous clears and two asynchronous clears. Each slot picks one of the lines, can invert it, and can be switched off.

A configuration word for each register chooses which enable it follows and which of the shared clears it obeys. A register that ignores all of them simply captures its data input on every clock edge. The group limits how many clear slots may be in service at once. An active-low device-wide clear input empties every register at once, whatever any other control says.

The block sits between the lookup logic that produces the register data inputs and the routing that carries the register outputs away. Both configuration buses are expected to be static while the group runs.

Top module: `lb_ctrl_gen`

## Requirements
- R1: All registers share the single clock `clk`. A register whose enable select is 0 captures `d_in` at each rising edge when no clear reaches it. `q_out` shows the new value after that edge.
- R2: Shared slot s takes the value of `ctrl_lines[slot_sel[3*s +: 3]]` XOR `slot_inv[s]` when `slot_use[s]` is 1. The slots are: 0 = enable A, 1 = enable B, 2 = sync clear A, 3 = sync clear B, 4 = async clear A, 5 = async clear B. An enable slot that is not in use reads as 1. A clear slot that is not in use reads as 0.
- R3: At most three clear slots are admitted, in the priority order async A, async B, sync A, sync B. When all four of `slot_use[5:2]` are set, `clr_cfg_err` is 1 and sync clear B has no effect on any register. Otherwise `clr_cfg_err` is 0.
- R4: Bits [1:0] of register i's configuration word (`reg_cfg[6*i +: 6]`) select its enable: 0 = always enabled, 1 = enable A, 2 = enable B, 3 = enable A AND enable B. A register that is not enabled keeps its value across the edge, and any synchronous clear it sees has no effect.
- R5: Bit 2 of the word obeys sync clear A and bit 3 obeys sync clear B. An enabled register that sees an obeyed synchronous clear at a rising edge becomes 0.
- R6: Bit 4 of the word obeys async clear A and bit 5 obeys async clear B. An obeyed asynchronous clear forces the register to 0 at once, without a clock edge and regardless of enable, and holds it at 0 while the clear stays active.
- R7: While `dev_clr_n` is 0, every register is 0 at once, whatever the configuration, the enables and `rst_n` are.
- R8: When `rst_n` is 0 at a rising edge, every register becomes 0 at that edge, even registers that are not enabled.
- R9: A register whose configuration word is 0 ignores all shared slots and follows `d_in` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Group clock |
| rst_n | input | 1 | Synchronous active-low reset of the register bank |
| dev_clr_n | input | 1 | Active-low device-wide clear, acts at once |
| ctrl_lines | input | 8 | Incoming control lines |
| slot_sel | input | 18 | Line index for each of the six slots, 3 bits per slot |
| slot_inv | input | 6 | Invert flag for each slot |
| slot_use | input | 6 | In-service flag for each slot |
| reg_cfg | input | 240 | Six-bit configuration word per register |
| d_in | input | 40 | Register data inputs |
| q_out | output | 40 | Register data outputs |
| clr_cfg_err | output | 1 | Clear budget exceeded |

## Verification
The block holds no state other than the forty data registers, so any internal fault shows up on `q_out`. A wrong slot selection, inversion or clear admission shows at the first rising edge where an affected register captures, holds or clears the wrong value. A wrong asynchronous path shows within the same clock phase as the change on the clear line. The bench sweeps all 64 combinations of slot use, and in those sweeps every one of the 64 register configuration words meets random lines and data. A bench model built from the requirements predicts every register after every edge.

// File: rtl/lbc_pkg.sv
// Package: shared constants and types of the logic-group control generator.
// Assumes slot order en A, en B, sclr A, sclr B, aclr A, aclr B.
package lbc_pkg;

    localparam int NSLOT    = 6;
    localparam int NUM_EN   = 2;
    localparam int CFG_W    = 6;
    localparam int SLOT_ENA = 0;
    localparam int SLOT_ENB = 1;
    localparam int SLOT_SCA = 2;
    localparam int SLOT_SCB = 3;
    localparam int SLOT_ACA = 4;
    localparam int SLOT_ACB = 5;

    typedef enum logic [1:0] {
        EN_ALWAYS = 2'd0,
        EN_USE_A  = 2'd1,
        EN_USE_B  = 2'd2,
        EN_BOTH   = 2'd3
    } en_sel_e;

    typedef struct packed {
        logic [1:0] aclr_m;
        logic [1:0] sclr_m;
        en_sel_e    en_sel;
    } reg_cfg_t;

endpackage

// File: rtl/lbc_clear_budget.sv
// Module: admits clear slots in priority order until the budget is used up.
// Assumes cand_use is ordered by priority (index 0 first). Flags a request
// over budget; candidates past the budget are dropped.
module lbc_clear_budget #(
    parameter int NCAND   = 4,
    parameter int MAX_CLR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCAND-1:0] cand_use,
    output logic [NCAND-1:0] admit,
    output logic             over_budget
);
    localparam int CNT_W = $clog2(NCAND + 1);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CLR);

    logic [CNT_W-1:0] run_cnt [NCAND+1];

    assign run_cnt[0] = '0;

    // Running count of admitted candidates, one stage per candidate.
    for (genvar k = 0; k < NCAND; k++) begin : g_admit
        assign admit[k]       = cand_use[k] && (run_cnt[k] < MAX_C);
        assign run_cnt[k+1]   = run_cnt[k] + CNT_W'(admit[k]);
    end

    // Error flag: more candidates requested than the budget allows.
    assign over_budget = ($countones(cand_use) > MAX_CLR);

    assert_clr_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(admit) <= MAX_CLR);

    assert_err_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        over_budget |-> (admit != cand_use));

endmodule

// File: rtl/lbc_line_select.sv
// Module: derives the six shared control slots from the incoming lines.
// Assumes slot_use is already filtered by the clear budget. Unused enable
// slots read 1; unused clear slots read 0.
module lbc_line_select
    import lbc_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int SEL_W  = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]      lines,
    input  logic [NSLOT*SEL_W-1:0] slot_sel,
    input  logic [NSLOT-1:0]       slot_inv,
    input  logic [NSLOT-1:0]       slot_use,
    output logic [NSLOT-1:0]       slot_val
);
    // One selector per slot; the idle value depends on the slot kind.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic IDLE_V = (s < NUM_EN) ? 1'b1 : 1'b0;
        logic [SEL_W-1:0] idx;
        logic             raw;
        assign idx         = slot_sel[s*SEL_W +: SEL_W];
        assign raw         = lines[idx] ^ slot_inv[s];
        assign slot_val[s] = slot_use[s] ? raw : IDLE_V;
    end

endmodule

// File: rtl/lbc_store_reg.sv
// Module: one storage register with per-register control decode.
// Assumes the clear inputs are the admitted shared slots. Priority:
// async clear (incl. device clear) > sync reset > enable > sync clear.
module lbc_store_reg
    import lbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dev_clr_n,
    input  reg_cfg_t cfg,
    input  logic     en_a,
    input  logic     en_b,
    input  logic     sclr_a,
    input  logic     sclr_b,
    input  logic     aclr_a,
    input  logic     aclr_b,
    input  logic     d,
    output logic     q
);
    logic en_eff;
    logic sclr_eff;
    logic aclr_eff;

    // Enable decode from the register's enable select.
    always_comb begin
        unique case (cfg.en_sel)
            EN_ALWAYS: en_eff = 1'b1;
            EN_USE_A:  en_eff = en_a;
            EN_USE_B:  en_eff = en_b;
            EN_BOTH:   en_eff = en_a & en_b;
            default:   en_eff = 1'b1;
        endcase
    end

    assign sclr_eff = |(cfg.sclr_m & {sclr_b, sclr_a});
    assign aclr_eff = !dev_clr_n || (|(cfg.aclr_m & {aclr_b, aclr_a}));

    // Data register with asynchronous clear and gated synchronous update.
    always_ff @(posedge clk or posedge aclr_eff) begin
        if (aclr_eff)      q <= 1'b0;
        else if (!rst_n)   q <= 1'b0;
        else if (en_eff)   q <= sclr_eff ? 1'b0 : d;
    end

    assert_sclr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && sclr_eff) |=> (q == 1'b0));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff) |=> ((q == $past(q)) || (q == 1'b0)));

    assert_aclr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aclr_eff |-> (q == 1'b0));

endmodule

// File: rtl/lb_ctrl_gen.sv
// Module: control generator and register bank of one logic group.
// Assumes slot_sel, slot_inv, slot_use and reg_cfg are static while running.
// Admits clear slots under the budget, derives shared controls and
// instantiates REGS_PER_CELL registers for each of NCELL cells.
module lb_ctrl_gen
    import lbc_pkg::*;
#(
    parameter int NCELL         = 10,
    parameter int REGS_PER_CELL = 4,
    parameter int NLINES        = 8,
    parameter int MAX_CLR       = 3,
    localparam int SEL_W        = $clog2(NLINES),
    localparam int NREG         = NCELL * REGS_PER_CELL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dev_clr_n,
    input  logic [NLINES-1:0]       ctrl_lines,
    input  logic [NSLOT*SEL_W-1:0]  slot_sel,
    input  logic [NSLOT-1:0]        slot_inv,
    input  logic [NSLOT-1:0]        slot_use,
    input  logic [NREG*CFG_W-1:0]   reg_cfg,
    input  logic [NREG-1:0]         d_in,
    output logic [NREG-1:0]         q_out,
    output logic                    clr_cfg_err
);
    localparam int NCAND = NSLOT - NUM_EN;

    logic [NCAND-1:0] cand_use;
    logic [NCAND-1:0] cand_admit;
    logic [NSLOT-1:0] eff_use;
    logic [NSLOT-1:0] slot_val;

    // Clear candidates in priority order: async A, async B, sync A, sync B.
    assign cand_use = {slot_use[SLOT_SCB], slot_use[SLOT_SCA],
                       slot_use[SLOT_ACB], slot_use[SLOT_ACA]};

    lbc_clear_budget #(.NCAND(NCAND), .MAX_CLR(MAX_CLR)) budget_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_use    (cand_use),
        .admit       (cand_admit),
        .over_budget (clr_cfg_err)
    );

    // Rebuild slot usage with only the admitted clears.
    assign eff_use = {cand_admit[1], cand_admit[0], cand_admit[3], cand_admit[2],
                      slot_use[SLOT_ENB], slot_use[SLOT_ENA]};

    lbc_line_select #(.NLINES(NLINES), .SEL_W(SEL_W)) select_i (
        .lines    (ctrl_lines),
        .slot_sel (slot_sel),
        .slot_inv (slot_inv),
        .slot_use (eff_use),
        .slot_val (slot_val)
    );

    // Register bank: REGS_PER_CELL registers in each cell.
    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        for (genvar r = 0; r < REGS_PER_CELL; r++) begin : g_reg
            localparam int IDX = c * REGS_PER_CELL + r;
            lbc_store_reg reg_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .dev_clr_n (dev_clr_n),
                .cfg       (reg_cfg_t'(reg_cfg[IDX*CFG_W +: CFG_W])),
                .en_a      (slot_val[SLOT_ENA]),
                .en_b      (slot_val[SLOT_ENB]),
                .sclr_a    (slot_val[SLOT_SCA]),
                .sclr_b    (slot_val[SLOT_SCB]),
                .aclr_a    (slot_val[SLOT_ACA]),
                .aclr_b    (slot_val[SLOT_ACB]),
                .d         (d_in[IDX]),
                .q         (q_out[IDX])
            );
        end
    end

    assert_devclr_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_clr_n) |-> (q_out == '0));

    assert_sclrb_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cfg_err |-> (eff_use[SLOT_SCB] == 1'b0));

endmodule

// File: tb/lb_ctrl_gen_tb.sv
`timescale 1ns/1ps
module lb_ctrl_gen_tb_top;
    localparam int NREG = 40;
    localparam time TCLK = 20ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             dev_clr_n;
    logic [7:0]       lines;
    logic [17:0]      ssel;
    logic [5:0]       sinv;
    logic [5:0]       suse;
    logic [NREG*6-1:0] cfg;
    logic [NREG-1:0]  d;
    logic [NREG-1:0]  q;
    logic             err;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic  exp_q [NREG];
    string exp_tag [NREG];

    always #(TCLK/2) clk = ~clk;

    lb_ctrl_gen dut_i (
        .clk(clk), .rst_n(rst_n), .dev_clr_n(dev_clr_n), .ctrl_lines(lines),
        .slot_sel(ssel), .slot_inv(sinv), .slot_use(suse), .reg_cfg(cfg),
        .d_in(d), .q_out(q), .clr_cfg_err(err)
    );

    // Slot value per R2 with the R3 budget applied.
    function automatic logic slot_v(input int s);
        logic u;
        u = suse[s];
        if (s == 3 && (&suse[5:2])) u = 1'b0;
        if (!u) return (s < 2) ? 1'b1 : 1'b0;
        return lines[ssel[3*s +: 3]] ^ sinv[s];
    endfunction

    function automatic logic async_of(input int i);
        logic [5:0] c;
        c = cfg[6*i +: 6];
        return !dev_clr_n || (c[4] && slot_v(4)) || (c[5] && slot_v(5));
    endfunction

    // Reference model, updated at each rising edge from the requirements.
    always @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            logic [5:0] c;
            logic en, sc;
            c = cfg[6*i +: 6];
            if (async_of(i)) begin
                exp_q[i] = 1'b0; exp_tag[i] = dev_clr_n ? "R6" : "R7";
            end else if (!rst_n) begin
                exp_q[i] = 1'b0; exp_tag[i] = "R8";
            end else begin
                case (c[1:0])
                    2'd0: en = 1'b1;
                    2'd1: en = slot_v(0);
                    2'd2: en = slot_v(1);
                    default: en = slot_v(0) && slot_v(1);
                endcase
                sc = (c[2] && slot_v(2)) || (c[3] && slot_v(3));
                if (!en) exp_tag[i] = "R4";
                else if (sc) begin exp_q[i] = 1'b0; exp_tag[i] = "R5"; end
                else begin
                    exp_q[i] = d[i];
                    if (c == 6'd0) exp_tag[i] = "R9";
                    else if (c[3] && (&suse[5:2])) exp_tag[i] = "R3";
                    else if (c[1:0] == 2'd0) exp_tag[i] = "R1";
                    else exp_tag[i] = "R2";
                end
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, ex, $time);
        end
    endtask

    // Compare every register against the model (called away from edges).
    task automatic check_all();
        for (int i = 0; i < NREG; i++) begin
            if (async_of(i)) check_bit(dev_clr_n ? "R6" : "R7", q[i], 1'b0);
            else             check_bit(exp_tag[i], q[i], exp_q[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin exp_q[i] = 1'b0; exp_tag[i] = "R8"; end
        rst_n = 1'b0; dev_clr_n = 1'b1; lines = '0; ssel = '0; sinv = '0;
        suse = '0; cfg = '0; d = '1;
        repeat (2) @(negedge clk);
        // R8: bank cleared by synchronous reset.
        for (int i = 0; i < NREG; i++) check_bit("R8", q[i], 1'b0);
        rst_n = 1'b1;

        // R3: error flag over every slot-use pattern.
        for (int u = 0; u < 64; u++) begin
            suse = 6'(u);
            #1;
            check_bit("R3", err, &suse[5:2]);
        end
        suse = '0;

        // R1/R9: load ones with no controls.
        @(negedge clk); d = '1; cfg = '0;
        @(negedge clk); check_all();
        // R6: async clear acts before any edge.
        for (int i = 0; i < NREG; i++) cfg[6*i +: 6] = 6'b010000;
        suse = 6'b010000; lines[0] = 1'b1;
        #2;
        for (int i = 0; i < NREG; i++) check_bit("R6", q[i], 1'b0);
        @(negedge clk); check_all();
        suse = '0; cfg = '0;
        @(negedge clk); check_all();
        // R7: device clear overrides even an ignore-all register.
        dev_clr_n = 1'b0;
        #2;
        for (int i = 0; i < NREG; i++) check_bit("R7", q[i], 1'b0);
        @(negedge clk); check_all();
        dev_clr_n = 1'b1;

        // Sweep: all slot-use patterns, rotating all 64 config words.
        for (int u = 0; u < 64; u++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check_all();
                suse  = 6'(u);
                lines = 8'($urandom);
                ssel  = 18'($urandom);
                sinv  = 6'($urandom);
                d     = {8'($urandom), 32'($urandom)};
                for (int i = 0; i < NREG; i++) cfg[6*i +: 6] = 6'((i + 5*k + u) % 64);
                rst_n     = ($urandom % 16) != 0;
                dev_clr_n = ($urandom % 16) != 0;
            end
        end
        @(negedge clk); check_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(TCLK * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule